// File: doc/BRIEF.md
# Triple-Channel Result Voter with Median Mode

This block sits behind three replicated processing channels that run in lockstep and hand it one result word each per step. It returns a single result word that masks one faulty channel. It also gives a code naming the channel that disagreed and a flag for the case where no two channels can be reconciled. Software or a supervisor reads the per-channel disagreement counters to tell a channel that is failing for good from one that suffered a one-off upset.

Two voting rules are available, picked per step by the `mode` input. Exact voting suits purely digital results: the output is any value carried by at least two channels. Median voting suits results taken from analog conversion, where healthy channels may differ in their low bits. The output is then the signed middle value, and a channel is only blamed when it lies more than a programmable tolerance away from that middle value. A channel whose valid strobe is missing in a step counts as disagreeing in that step. To protect against a failure of the voter itself, the block is meant to be placed three times side by side; it holds no state shared between copies.

Top module: `tmr_vote`

## Requirements
- R1: While `rst_n` is low and after its release, `out_vld`, `out_dat`, `out_odd`, `out_uncorr` and all three counters in `err_cnt` are zero.
- R2: A step is any cycle in which at least one bit of `ch_vld` is high. `out_vld` is high exactly in the cycle after a step, and `out_dat`, `out_odd` and `out_uncorr` change only on that edge.
- R3: With `mode` = 0 and all channels valid, `out_dat` is a value held by at least two channels. `out_odd` is 0 when all three agree and otherwise gives the index + 1 of the differing channel (1 = ch0, 2 = ch1, 3 = ch2).
- R4: With `mode` = 0, all channels valid and all three values distinct, `out_uncorr` is 1, `out_odd` is 0 and `out_dat` keeps its previous value.
- R5: With `mode` = 1 and all channels valid, `out_dat` is the median of the three inputs read as two's-complement signed numbers.
- R6: With `mode` = 1 and all channels valid, a channel is flagged in `out_odd` (same code as R3) when the absolute difference between its value and the median exceeds the unsigned `tol`. A difference equal to `tol` is not flagged.
- R7: With `mode` = 1 and all channels valid, if both non-median channels exceed `tol`, `out_uncorr` is 1, `out_odd` is 0 and `out_dat` is held.
- R8: When exactly one channel lacks its valid bit, it is reported in `out_odd` if the two valid channels agree (equal in mode 0, within `tol` in mode 1), and `out_dat` takes the lower-index valid channel. If they do not agree, the step is uncorrectable, as in R4.
- R9: A step with exactly one valid channel is uncorrectable: `out_uncorr` = 1 and `out_dat` is held.
- R10: Counter k (`err_cnt[k*CNT_W +: CNT_W]`) increments on each step whose `out_odd` names channel k. It saturates at 2^CNT_W - 1 and does not change on uncorrectable steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0 = exact majority, 1 = signed median with tolerance |
| tol | input | W | Unsigned tolerance for median mode |
| ch_vld | input | 3 | Per-channel valid, bit k for channel k |
| ch0_dat | input | W | Result of channel 0 |
| ch1_dat | input | W | Result of channel 1 |
| ch2_dat | input | W | Result of channel 2 |
| out_vld | output | 1 | Voted result is present this cycle |
| out_dat | output | W | Voted result word |
| out_odd | output | 2 | Disagreeing channel code: 0 none, 1..3 channel index + 1 |
| out_uncorr | output | 1 | No reconcilable pair in the last step |
| err_cnt | output | 3*CNT_W | Saturating disagreement counters, channel k in slice k |

## Verification
The hardest situation to reach from the ports is counter saturation together with the hold behaviour. A counter has to be driven past its top value by a long run of steps that each blame the same channel. Uncorrectable steps are mixed in and must leave both the counter and the held output alone. The stimulus repeats a step with one bad channel more times than the counter range, then adds an all-distinct step. In median mode, inputs at exactly the tolerance edge, along with negative values, show whether the comparison is signed and whether the tolerance bound is inclusive.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

   typedef enum logic {
      VOTE_EXACT  = 1'b0,
      VOTE_MEDIAN = 1'b1
   } vote_mode_e;

   localparam int unsigned NCH   = 3;
   localparam int unsigned CODEW = 2;

   localparam logic [CODEW-1:0] CODE_NONE = 2'd0;

   function automatic logic [CODEW-1:0] chan_code(input int unsigned idx);
      return CODEW'(idx + 1);
   endfunction

endpackage

// File: rtl/tmr_vote_exact.sv
module tmr_vote_exact
   import tmr_vote_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [NCH-1:0]        vld,
   input  logic [NCH-1:0][W-1:0] din,
   output logic [W-1:0]          sel,
   output logic [CODEW-1:0]      odd,
   output logic                  unc
);

   logic eq01, eq02, eq12;

   always_comb begin
      eq01 = vld[0] && vld[1] && (din[0] == din[1]);
      eq02 = vld[0] && vld[2] && (din[0] == din[2]);
      eq12 = vld[1] && vld[2] && (din[1] == din[2]);
      sel  = '0;
      odd  = CODE_NONE;
      unc  = 1'b0;
      if (eq01) begin
         sel = din[0];
         if (!vld[2] || (din[2] != din[0])) odd = chan_code(2);
      end else if (eq02) begin
         sel = din[0];
         odd = chan_code(1);
      end else if (eq12) begin
         sel = din[1];
         odd = chan_code(0);
      end else begin
         unc = 1'b1;
      end
   end

endmodule

// File: rtl/tmr_vote_median.sv
module tmr_vote_median
   import tmr_vote_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [NCH-1:0]        vld,
   input  logic [NCH-1:0][W-1:0] din,
   input  logic [W-1:0]          tol,
   output logic [W-1:0]          sel,
   output logic [CODEW-1:0]      odd,
   output logic                  unc
);

   localparam int unsigned DW = W + 1;

   function automatic logic is_mid(input logic [W-1:0] x,
                                   input logic [W-1:0] y,
                                   input logic [W-1:0] z);
      logic up, dn;
      up = ($signed(x) >= $signed(y)) && ($signed(x) <= $signed(z));
      dn = ($signed(x) <= $signed(y)) && ($signed(x) >= $signed(z));
      return up || dn;
   endfunction

   function automatic logic [DW-1:0] gap(input logic [W-1:0] a,
                                         input logic [W-1:0] b);
      logic signed [DW-1:0] d;
      d = $signed({a[W-1], a}) - $signed({b[W-1], b});
      return d[DW-1] ? DW'(-d) : DW'(d);
   endfunction

   logic [1:0]     mid_idx;
   logic [1:0]     lo_idx, hi_idx;
   logic [NCH-1:0] far;
   logic           pair;
   logic [CODEW-1:0] miss_code;
   logic [DW-1:0]  tol_x;

   assign tol_x = {1'b0, tol};

   always_comb begin
      sel       = '0;
      odd       = CODE_NONE;
      unc       = 1'b0;
      far       = '0;
      pair      = 1'b0;
      lo_idx    = 2'd0;
      hi_idx    = 2'd1;
      miss_code = CODE_NONE;
      mid_idx   = 2'd2;
      if (is_mid(din[0], din[1], din[2]))      mid_idx = 2'd0;
      else if (is_mid(din[1], din[0], din[2])) mid_idx = 2'd1;

      case (vld)
         3'b111: begin
            sel = din[mid_idx];
            for (int i = 0; i < NCH; i++) begin
               far[i] = (2'(i) != mid_idx) && (gap(din[i], din[mid_idx]) > tol_x);
            end
            case (far)
               3'b000:  odd = CODE_NONE;
               3'b001:  odd = chan_code(0);
               3'b010:  odd = chan_code(1);
               3'b100:  odd = chan_code(2);
               default: unc = 1'b1;
            endcase
         end
         3'b011: begin pair = 1'b1; lo_idx = 2'd0; hi_idx = 2'd1; miss_code = chan_code(2); end
         3'b101: begin pair = 1'b1; lo_idx = 2'd0; hi_idx = 2'd2; miss_code = chan_code(1); end
         3'b110: begin pair = 1'b1; lo_idx = 2'd1; hi_idx = 2'd2; miss_code = chan_code(0); end
         default: unc = 1'b1;
      endcase

      if (pair) begin
         if (gap(din[lo_idx], din[hi_idx]) <= tol_x) begin
            sel = din[lo_idx];
            odd = miss_code;
         end else begin
            unc = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tmr_vote_satcnt.sv
module tmr_vote_satcnt #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc && (cnt != TOP)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_vote.sv
module tmr_vote
   import tmr_vote_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode,
   input  logic [W-1:0]       tol,
   input  logic [2:0]         ch_vld,
   input  logic [W-1:0]       ch0_dat,
   input  logic [W-1:0]       ch1_dat,
   input  logic [W-1:0]       ch2_dat,
   output logic               out_vld,
   output logic [W-1:0]       out_dat,
   output logic [1:0]         out_odd,
   output logic               out_uncorr,
   output logic [3*CNT_W-1:0] err_cnt
);

   if (W < 2) begin : g_bad_width
      $error("tmr_vote: W must be at least 2");
   end
   if ((CNT_W < 1) || (CNT_W > 32)) begin : g_bad_cnt
      $error("tmr_vote: CNT_W must lie in 1..32");
   end

   logic [NCH-1:0][W-1:0] din;
   logic [W-1:0]          ex_sel, md_sel, pick_sel;
   logic [CODEW-1:0]      ex_odd, md_odd, pick_odd;
   logic                  ex_unc, md_unc, pick_unc;
   logic                  step;
   vote_mode_e            vmode;

   assign din   = {ch2_dat, ch1_dat, ch0_dat};
   assign step  = |ch_vld;
   assign vmode = vote_mode_e'(mode);

   tmr_vote_exact #(.W(W)) u_exact (
      .vld (ch_vld),
      .din (din),
      .sel (ex_sel),
      .odd (ex_odd),
      .unc (ex_unc)
   );

   tmr_vote_median #(.W(W)) u_median (
      .vld (ch_vld),
      .din (din),
      .tol (tol),
      .sel (md_sel),
      .odd (md_odd),
      .unc (md_unc)
   );

   always_comb begin
      if (vmode == VOTE_MEDIAN) begin
         pick_sel = md_sel;
         pick_odd = md_odd;
         pick_unc = md_unc;
      end else begin
         pick_sel = ex_sel;
         pick_odd = ex_odd;
         pick_unc = ex_unc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld    <= 1'b0;
         out_dat    <= '0;
         out_odd    <= CODE_NONE;
         out_uncorr <= 1'b0;
      end else begin
         out_vld <= step;
         if (step) begin
            out_uncorr <= pick_unc;
            out_odd    <= pick_unc ? CODE_NONE : pick_odd;
            if (!pick_unc) out_dat <= pick_sel;
         end
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_cnt
      logic bump;
      assign bump = step && !pick_unc && (pick_odd == chan_code(k));
      tmr_vote_satcnt #(.CW(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (bump),
         .cnt   (err_cnt[k*CNT_W +: CNT_W])
      );
   end

endmodule

// File: rtl/tmr_vote_chk.sv
module tmr_vote_chk #(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode,
   input logic [2:0]         ch_vld,
   input logic [W-1:0]       ch0_dat,
   input logic [W-1:0]       ch1_dat,
   input logic [W-1:0]       ch2_dat,
   input logic               out_vld,
   input logic [W-1:0]       out_dat,
   input logic [1:0]         out_odd,
   input logic               out_uncorr,
   input logic [3*CNT_W-1:0] err_cnt
);

   localparam logic [CNT_W-1:0] TOP = '1;

   // R2
   step_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_vld) |=> out_vld);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ch_vld) |=> !out_vld);

   // R3
   all_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && (&ch_vld) && (ch0_dat == ch1_dat) && (ch1_dat == ch2_dat))
      |=> (out_dat == $past(ch0_dat)) && (out_odd == 2'd0));

   // R4
   hold_on_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_uncorr) |-> $stable(out_dat));

   // R4
   unc_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_uncorr |-> (out_odd == 2'd0));

   // R9
   lone_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ch_vld) == 1) |=> out_uncorr);

   // R10
   cnt0_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt[0 +: CNT_W] == TOP) |=> (err_cnt[0 +: CNT_W] == TOP));

   // R10
   cnt1_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt[CNT_W +: CNT_W] >= $past(err_cnt[CNT_W +: CNT_W]));

   // R10
   cnt2_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt[2*CNT_W +: CNT_W] >= $past(err_cnt[2*CNT_W +: CNT_W]));

endmodule

bind tmr_vote tmr_vote_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .ch_vld     (ch_vld),
   .ch0_dat    (ch0_dat),
   .ch1_dat    (ch1_dat),
   .ch2_dat    (ch2_dat),
   .out_vld    (out_vld),
   .out_dat    (out_dat),
   .out_odd    (out_odd),
   .out_uncorr (out_uncorr),
   .err_cnt    (err_cnt)
);

// File: tb/tmr_vote_tb.sv
`timescale 1ns/1ps
module tmr_vote_tb;

   localparam int W     = 16;
   localparam int CNT_W = 4;
   localparam int CMAX  = (1 << CNT_W) - 1;

   typedef struct {
      logic [W-1:0] dat;
      logic [1:0]   odd;
      logic         unc;
      int           c0, c1, c2;
      string        tag;
   } item_t;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               mode;
   logic [W-1:0]       tol;
   logic [2:0]         ch_vld;
   logic [W-1:0]       ch0_dat, ch1_dat, ch2_dat;
   logic               out_vld;
   logic [W-1:0]       out_dat;
   logic [1:0]         out_odd;
   logic               out_uncorr;
   logic [3*CNT_W-1:0] err_cnt;

   int checks = 0;
   int errors = 0;
   item_t exp_q[$];
   logic [W-1:0] m_hold = '0;
   int m_cnt[3] = '{0, 0, 0};

   always #2.5 clk = ~clk;

   tmr_vote #(.W(W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tol(tol), .ch_vld(ch_vld),
      .ch0_dat(ch0_dat), .ch1_dat(ch1_dat), .ch2_dat(ch2_dat),
      .out_vld(out_vld), .out_dat(out_dat), .out_odd(out_odd),
      .out_uncorr(out_uncorr), .err_cnt(err_cnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int sdist(input logic [W-1:0] a, input logic [W-1:0] b);
      int d;
      d = int'($signed(a)) - int'($signed(b));
      return (d < 0) ? -d : d;
   endfunction

   task automatic model(input logic m, input logic [W-1:0] t, input logic [2:0] v,
                        input logic [W-1:0] a0, a1, a2, input string tag,
                        output item_t it);
      logic [W-1:0] d[3];
      int nv, win, nfar, farch;
      d[0] = a0; d[1] = a1; d[2] = a2;
      nv = int'(v[0]) + int'(v[1]) + int'(v[2]);
      it.unc = 1'b0; it.odd = 2'd0; it.dat = m_hold; it.tag = tag;
      if (nv < 2) begin
         it.unc = 1'b1;
      end else if (nv == 2) begin
         int lo, hi, ms;
         lo = -1; hi = -1; ms = -1;
         for (int i = 0; i < 3; i++) begin
            if (!v[i]) ms = i;
            else if (lo < 0) lo = i;
            else hi = i;
         end
         if (m ? (sdist(d[lo], d[hi]) <= int'(t)) : (d[lo] == d[hi])) begin
            it.dat = d[lo]; it.odd = 2'(ms + 1);
         end else it.unc = 1'b1;
      end else if (!m) begin
         win = -1;
         for (int c = 2; c >= 0; c--) begin
            int n;
            n = 0;
            for (int j = 0; j < 3; j++) if (d[j] == d[c]) n++;
            if (n >= 2) win = c;
         end
         if (win < 0) it.unc = 1'b1;
         else begin
            it.dat = d[win];
            for (int j = 0; j < 3; j++) if (d[j] != d[win]) it.odd = 2'(j + 1);
         end
      end else begin
         logic [W-1:0] s[3];
         logic [W-1:0] tmp;
         s = d;
         for (int p = 0; p < 2; p++)
            for (int q = 0; q < 2 - p; q++)
               if ($signed(s[q]) > $signed(s[q+1])) begin
                  tmp = s[q]; s[q] = s[q+1]; s[q+1] = tmp;
               end
         nfar = 0; farch = 0;
         for (int j = 0; j < 3; j++)
            if (sdist(d[j], s[1]) > int'(t)) begin nfar++; farch = j + 1; end
         if (nfar >= 2) it.unc = 1'b1;
         else begin it.dat = s[1]; it.odd = 2'(farch); end
      end
      if (it.unc) it.odd = 2'd0;
      else begin
         m_hold = it.dat;
         if (it.odd != 2'd0 && m_cnt[it.odd - 1] < CMAX) m_cnt[it.odd - 1]++;
      end
      it.c0 = m_cnt[0]; it.c1 = m_cnt[1]; it.c2 = m_cnt[2];
   endtask

   task automatic send(input logic m, input int t, input logic [2:0] v,
                       input int a0, input int a1, input int a2, input string tag);
      item_t it;
      @(negedge clk);
      mode = m; tol = W'(t); ch_vld = v;
      ch0_dat = W'(a0); ch1_dat = W'(a1); ch2_dat = W'(a2);
      model(m, W'(t), v, W'(a0), W'(a1), W'(a2), tag, it);
      exp_q.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ch_vld = 3'b000;
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected out_vld", 1, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            check({e.tag, " out_dat"}, int'(out_dat), int'(e.dat));
            check({e.tag, " out_odd"}, int'(out_odd), int'(e.odd));
            check({e.tag, " out_uncorr"}, int'(out_uncorr), int'(e.unc));
            check({e.tag, " R10 cnt0"}, int'(err_cnt[0 +: CNT_W]), e.c0);
            check({e.tag, " R10 cnt1"}, int'(err_cnt[CNT_W +: CNT_W]), e.c1);
            check({e.tag, " R10 cnt2"}, int'(err_cnt[2*CNT_W +: CNT_W]), e.c2);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; mode = 1'b0; tol = '0; ch_vld = 3'b000;
      ch0_dat = '0; ch1_dat = '0; ch2_dat = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_vld", int'(out_vld), 0);
      check("R1 out_dat", int'(out_dat), 0);
      check("R1 out_odd", int'(out_odd), 0);
      check("R1 out_uncorr", int'(out_uncorr), 0);
      check("R1 err_cnt", int'(err_cnt), 0);

      // exact mode
      send(1'b0, 0, 3'b111, 77, 77, 77, "R3 all agree");
      send(1'b0, 0, 3'b111, 5, 5, 9, "R3 ch2 odd");
      send(1'b0, 0, 3'b111, 8, 3, 8, "R3 ch1 odd");
      idle(2);
      send(1'b0, 0, 3'b111, 1, 4, 4, "R3 ch0 odd");
      send(1'b0, 0, 3'b111, 1, 2, 3, "R4 all distinct");
      send(1'b0, 0, 3'b111, 11, 22, 33, "R4 still held");

      // median mode
      send(1'b1, 8, 3'b111, 100, 103, 98, "R5 R6 inside tol");
      send(1'b1, 2, 3'b111, 100, 103, 98, "R6 ch1 beyond tol");
      send(1'b1, 3, 3'b111, 100, 103, 98, "R6 at tol edge");
      send(1'b1, 4, 3'b111, -50, -48, 300, "R5 signed median");
      send(1'b1, 5, 3'b111, 10, -500, 500, "R7 both far");
      send(1'b1, 0, 3'b111, -7, -9, -8, "R5 negative median");

      // missing valids
      send(1'b0, 0, 3'b011, 42, 42, 9, "R8 exact ch2 missing");
      send(1'b0, 0, 3'b110, 1, 2, 3, "R8 exact pair split");
      send(1'b1, 3, 3'b101, 40, 0, 42, "R8 median ch1 missing");
      send(1'b1, 1, 3'b110, 0, 60, 70, "R8 median pair far");
      send(1'b0, 0, 3'b001, 5, 6, 7, "R9 lone valid");
      idle(1);

      // saturation of counter 1
      for (int i = 0; i < CMAX + 5; i++) send(1'b0, 0, 3'b111, 9, 1, 9, "R10 saturate");
      send(1'b0, 0, 3'b111, 1, 2, 3, "R10 unc no count");
      send(1'b0, 0, 3'b111, 9, 1, 9, "R10 stay top");
      idle(4);

      check("R2 scoreboard drained", exp_q.size(), 0);
      check("R10 final cnt1", int'(err_cnt[CNT_W +: CNT_W]), CMAX);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule